// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the logic-level feedback path of an integer-N frequency synthesizer. It counts edges of the oscillator-rate clock through a dual-modulus prescaler and two programmable down-counters: a swallow count `A` and a main count `B`. While the swallow count is non-zero, the modulus-control line is high and the prescaler divides by P+1. Once the swallow count is exhausted, the prescaler divides by P until the main count runs out. A complete output period is therefore P·B + A input cycles. At the end of each period the block emits a one-cycle pulse for the phase detector.

The base modulus P is a power of two chosen by one select bit between two neighbouring sizes. A parameter builds a narrow variant that uses only the low four bits of the swallow value. Programmed values are sampled only at the reload boundary, so a period that has started always runs to its full length. A power-down input freezes the divider in place. A counter-reset input restarts the period from the current programmed values.

Top module: `psw_divider`

## Requirements
- R1: In steady operation, consecutive `div_pulse` assertions are exactly P·B + A clock cycles apart, for legal values 3 ≤ B ≤ 2047 and 0 ≤ A ≤ B.
- R2: `mod_sel` = 0 selects P = 2^P_LO_LOG2 and `mod_sel` = 1 selects P = 2^(P_LO_LOG2+1). The prescaler pair is therefore P/P+1 in both cases.
- R3: Within each period, `mod_ctl` is high for exactly A·(P+1) cycles, which is the first A prescaler cycles, and low for the rest.
- R4: With NARROW = 1, bits 6..4 of `a_val` are ignored and A is taken from bits 3..0 alone, giving a range of 0 to 15.
- R5: `div_pulse` is high for exactly one clock cycle per period.
- R6: A change of `a_val`, `b_val` or `mod_sel` during a period does not alter that period. The new values govern the period that starts at the next pulse.
- R7: While `pwrdn` is high, the counters hold their state, `div_pulse` stays low and `mod_ctl` does not change. The period containing the power-down is lengthened by exactly the number of held cycles.
- R8: A cycle with `cnt_rst` high restarts the period from the current inputs. The next pulse comes P·B + A cycles after that edge, and `div_pulse` is low in the cycle that follows it.
- R9: Synchronous reset `rst` loads the current inputs and holds `div_pulse` low, with `mod_ctl` equal to (A ≠ 0). The first pulse arrives P·B + A cycles after the last reset edge.
- R10: The prescaler's internal count never exceeds its current terminal value, which is P−1 or P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Freeze the divider while high |
| cnt_rst | input | 1 | Restart the current period from the present inputs |
| a_val | input | 7 | Swallow count A |
| b_val | input | 11 | Main count B |
| mod_sel | input | 1 | Base modulus size select |
| div_pulse | output | 1 | One-cycle pulse at the end of each period |
| mod_ctl | output | 1 | Prescaler modulus control, high while dividing by P+1 |

## Verification
The bench builds the divider with P_LO_LOG2 = 3 and NARROW = 1, which gives the 8/9 and 16/17 prescaler pairs. With these values every period lasts at most a few hundred cycles. This makes it possible to sweep every legal A for every B from 3 to 12 under both moduli, measuring each period length and the number of cycles `mod_ctl` is high against P·B + A and A·(P+1). The narrow build also exposes the masking of the upper swallow bits. Short periods also leave room for directed runs of a mid-period reprogram, a power-down window and a counter restart.

// File: rtl/psw_pkg.sv
`timescale 1ns/1ps
package psw_pkg;
    localparam int A_W        = 7;
    localparam int B_W        = 11;
    localparam int NARROW_A_W = 4;

    typedef logic [A_W-1:0] a_t;
    typedef logic [B_W-1:0] b_t;

    // Programmed values as sampled at a reload boundary
    typedef struct packed {
        a_t   a;
        b_t   b;
        logic sel;
    } psw_cfg_t;

    // Running state of the counters
    typedef struct packed {
        a_t   a_rem;
        b_t   b_rem;
        logic sel;
    } psw_state_t;

    function automatic a_t narrow_mask(a_t a);
        return a & a_t'((1 << NARROW_A_W) - 1);
    endfunction
endpackage

// File: rtl/psw_cfg_in.sv
`timescale 1ns/1ps
module psw_cfg_in
    import psw_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  a_t       a_raw,
    input  b_t       b_raw,
    input  logic     sel_raw,
    output psw_cfg_t cfg
);
    generate
        if (NARROW) begin : g_narrow
            always_comb begin
                cfg.a   = narrow_mask(a_raw);
                cfg.b   = b_raw;
                cfg.sel = sel_raw;
            end
        end else begin : g_wide
            always_comb begin
                cfg.a   = a_raw;
                cfg.b   = b_raw;
                cfg.sel = sel_raw;
            end
        end
    endgenerate
endmodule

// File: rtl/psw_prescaler.sv
`timescale 1ns/1ps
module psw_prescaler #(
    parameter int P_LO_LOG2 = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic hold,
    input  logic sel,
    input  logic swallow,
    output logic tick
);
    localparam int PC_W = P_LO_LOG2 + 2;
    localparam logic [PC_W-1:0] P_LO = PC_W'(1 << P_LO_LOG2);
    localparam logic [PC_W-1:0] P_HI = PC_W'(1 << (P_LO_LOG2 + 1));

    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] last;

    always_comb begin
        last = (sel ? P_HI : P_LO) - PC_W'(1) + PC_W'(swallow);
        tick = !hold && (pc == last);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pc <= '0;
        end else if (!hold) begin
            pc <= tick ? '0 : pc + PC_W'(1);
        end
    end

    // R10
    pc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pc <= last);
endmodule

// File: rtl/psw_swallow_ctr.sv
`timescale 1ns/1ps
module psw_swallow_ctr
    import psw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     hold,
    input  logic     tick,
    input  psw_cfg_t cfg,
    output logic     swallow,
    output logic     sel,
    output logic     pulse
);
    psw_state_t st;
    logic       last_cyc;

    always_comb begin
        last_cyc = tick && (st.b_rem == b_t'(1));
        swallow  = (st.a_rem != '0);
        sel      = st.sel;
    end

    always_ff @(posedge clk) begin
        pulse <= 1'b0;
        if (rst || restart) begin
            st.a_rem <= cfg.a;
            st.b_rem <= cfg.b;
            st.sel   <= cfg.sel;
        end else if (!hold && tick) begin
            if (last_cyc) begin
                st.a_rem <= cfg.a;
                st.b_rem <= cfg.b;
                st.sel   <= cfg.sel;
                pulse    <= 1'b1;
            end else begin
                st.b_rem <= st.b_rem - b_t'(1);
                if (st.a_rem != '0) st.a_rem <= st.a_rem - a_t'(1);
            end
        end
    end

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    // R3
    mod_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(swallow) && !$past(restart)) |-> $past(tick));
endmodule

// File: rtl/psw_divider.sv
`timescale 1ns/1ps
module psw_divider
    import psw_pkg::*;
#(
    parameter int P_LO_LOG2 = 6,
    parameter bit NARROW    = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pwrdn,
    input  logic           cnt_rst,
    input  logic [A_W-1:0] a_val,
    input  logic [B_W-1:0] b_val,
    input  logic           mod_sel,
    output logic           div_pulse,
    output logic           mod_ctl
);
    psw_cfg_t cfg;
    logic     tick;
    logic     swallow;
    logic     cur_sel;
    logic     hold;

    assign hold = pwrdn && !cnt_rst;

    psw_cfg_in #(.NARROW(NARROW)) u_cfg (
        .a_raw  (a_val),
        .b_raw  (b_val),
        .sel_raw(mod_sel),
        .cfg    (cfg)
    );

    psw_prescaler #(.P_LO_LOG2(P_LO_LOG2)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .restart(cnt_rst),
        .hold   (hold),
        .sel    (cur_sel),
        .swallow(swallow),
        .tick   (tick)
    );

    psw_swallow_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .restart(cnt_rst),
        .hold   (hold),
        .tick   (tick),
        .cfg    (cfg),
        .swallow(swallow),
        .sel    (cur_sel),
        .pulse  (div_pulse)
    );

    assign mod_ctl = swallow;

    // R7
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pwrdn && !cnt_rst) |=> ($stable(mod_ctl) && !div_pulse));

    // R8
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |=> !div_pulse);
endmodule

// File: tb/sim_psw_divider.sv
`timescale 1ns/1ps
module sim_psw_divider;
    localparam int L  = 3;
    localparam int P0 = 1 << L;
    localparam int P1 = 1 << (L + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwrdn = 1'b0;
    logic        cnt_rst = 1'b0;
    logic [6:0]  a_val = '0;
    logic [10:0] b_val = 11'd3;
    logic        mod_sel = 1'b0;
    logic        div_pulse;
    logic        mod_ctl;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 4 ns period
    always @(posedge clk) cyc <= cyc + 1;

    psw_divider #(.P_LO_LOG2(L), .NARROW(1'b1)) u0 (
        .clk(clk), .rst(rst), .pwrdn(pwrdn), .cnt_rst(cnt_rst),
        .a_val(a_val), .b_val(b_val), .mod_sel(mod_sel),
        .div_pulse(div_pulse), .mod_ctl(mod_ctl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int at, output int mc);
        mc = 0;
        at = -1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (mod_ctl) mc++;
            if (div_pulse) begin
                at = cyc;
                return;
            end
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: no pulse actual=timeout expected=pulse");
    endtask

    function automatic int pval(input logic s);
        return s ? P1 : P0;
    endfunction

    // Program, skip the period in flight, then measure one full period (R1, R2, R3, R5)
    task automatic run_cfg(input logic [6:0] a_drv, input int a_eff, input int b, input logic s);
        int t0, t1, mc;
        a_val = a_drv; b_val = 11'(b); mod_sel = s;
        wait_pulse(t0, mc);
        wait_pulse(t1, mc);
        chk("R1/R2 period", t1 - t0, pval(s) * b + a_eff);
        chk("R3 mod_ctl high cycles", mc, a_eff * (pval(s) + 1));
        @(negedge clk);
        chk("R5 pulse width", int'(div_pulse), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int t0, t1, t2, mc, c, m0;
        // R9: reset state and first period
        a_val = 7'd2; b_val = 11'd4; mod_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 pulse in reset", int'(div_pulse), 0);
        chk("R9 mod_ctl in reset", int'(mod_ctl), 1);
        c = cyc;
        rst = 1'b0;
        wait_pulse(t0, mc);
        chk("R9 first period", t0 - c, P0 * 4 + 2);

        // R4: upper swallow bits ignored in the narrow build
        run_cfg(7'h53, 3, 5, 1'b0);
        run_cfg(7'h7F, 15, 20, 1'b1);

        // R1 R2 R3: sweep of every legal A for small B, both moduli
        for (int s = 0; s < 2; s++)
            for (int b = 3; b <= 12; b++)
                for (int a = 0; a <= b; a++)
                    run_cfg(7'(a), a, b, 1'(s));

        // R6: reprogram mid-period, takes effect one period later
        a_val = 7'd1; b_val = 11'd3; mod_sel = 1'b0;
        wait_pulse(t0, mc);
        wait_pulse(t0, mc);
        repeat (3) @(negedge clk);
        a_val = 7'd4; b_val = 11'd6; mod_sel = 1'b1;
        wait_pulse(t1, mc);
        chk("R6 old period kept", t1 - t0, P0 * 3 + 1);
        wait_pulse(t2, mc);
        chk("R6 new period", t2 - t1, P1 * 6 + 4);

        // R7: power-down window of 7 cycles
        wait_pulse(t0, mc);
        repeat (5) @(negedge clk);
        pwrdn = 1'b1;
        m0 = int'(mod_ctl);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            chk("R7 no pulse in power-down", int'(div_pulse), 0);
            chk("R7 mod_ctl held", int'(mod_ctl), m0);
        end
        pwrdn = 1'b0;
        wait_pulse(t1, mc);
        chk("R7 extended period", t1 - t0, P1 * 6 + 4 + 7);

        // R8: counter reset with new values applies at once
        wait_pulse(t0, mc);
        repeat (4) @(negedge clk);
        c = cyc;
        a_val = 7'd2; b_val = 11'd7; mod_sel = 1'b0;
        cnt_rst = 1'b1;
        @(negedge clk);
        cnt_rst = 1'b0;
        chk("R8 no pulse after restart", int'(div_pulse), 0);
        wait_pulse(t1, mc);
        chk("R8 restart period", t1 - c, 1 + P0 * 7 + 2);
        wait_pulse(t2, mc);
        chk("R8 steady after restart", t2 - t1, P0 * 7 + 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule